// File: doc/BRIEF.md
# Command-Driven Shift Register

This block holds one data word and, on every rising clock edge, replaces it according to a two-bit operation code: a parallel load of a new word, a one-place move towards the most significant end, or a one-place move towards the least significant end. The move towards the least significant end has two forms. The logical form fills the vacated top bit with zero. The arithmetic form copies the old top bit into itself, so a two's-complement word keeps its sign.

The word is visible at the output at all times. An active-high asynchronous reset clears it without waiting for a clock. The width is a parameter and defaults to 8 bits. The operation encoding is fixed, because surrounding logic decodes it.

Top module: `shift_cmd_reg`

## Requirements
- R1: With `op` = 2'b00 at a rising edge, `value` takes the word present on `load_data` at that edge.
- R2: With `op` = 2'b01 at a rising edge, every bit of `value` moves one place towards the MSB, the old MSB is dropped and bit 0 becomes 0. For 8 bits, the new value is (old × 2) mod 256.
- R3: With `op` = 2'b10 at a rising edge, every bit moves one place towards bit 0, the old bit 0 is dropped and the MSB becomes 0. The new value is old / 2, rounded down, unsigned.
- R4: With `op` = 2'b11 at a rising edge, every bit moves one place towards bit 0 and the MSB keeps its previous value. For 8 bits, the new value is old / 2 plus 128 when old ≥ 128.
- R5: While `arst` is high, `value` is 8'h00 (all zeros). It clears as soon as `arst` rises, with no clock edge needed.
- R6: `value` changes only at a rising clock edge. Changes on `load_data` or `op` between edges leave it unchanged.
- R7: Repeating the arithmetic move on a negative word converges to all ones. Repeating it on a non-negative word converges to zero.
- R8: Loading 8'hC0, then one move towards the MSB and two logical moves towards bit 0, gives 8'h80, 8'h40 and 8'h20 in turn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the word updates on its rising edge |
| arst | input | 1 | Asynchronous reset, active high; clears the word |
| load_data | input | WIDTH | Word taken in by the load operation |
| op | input | 2 | Operation code: 00 load, 01 toward MSB, 10 logical toward bit 0, 11 arithmetic toward bit 0 |
| value | output | WIDTH | Current contents of the register |

## Verification
The clocked assertions assume that `op` and `load_data` are stable and known around each rising edge. They are ignored while `arst` is high, so they say nothing about the cycle in which reset is released. The bench drives every input on the falling edge, half a period away from the capturing edge, and samples `value` one nanosecond after the rising edge. It raises reset only between edges, and it checks the cleared word before the next edge arrives.

// File: rtl/shcr_pkg.sv
package shcr_pkg;

    // Operation encoding, fixed by the block's contract.
    typedef enum logic [1:0] {
        OP_LOAD    = 2'b00,
        OP_TO_MSB  = 2'b01,
        OP_LSB_LOG = 2'b10,
        OP_LSB_ARI = 2'b11
    } op_e;

    // Decoded selects used by the per-bit datapath.
    typedef struct packed {
        logic take_load;   // parallel word in
        logic take_lower;  // each bit takes its lower neighbour
        logic keep_sign;   // top bit refills from itself on right moves
    } sel_t;

endpackage

// File: rtl/shcr_decode.sv
module shcr_decode
    import shcr_pkg::*;
(
    input  logic [1:0] op,
    output sel_t       sel
);

    always_comb begin
        sel = '0;
        case (op_e'(op))
            OP_LOAD:    sel.take_load  = 1'b1;
            OP_TO_MSB:  sel.take_lower = 1'b1;
            OP_LSB_LOG: sel.keep_sign  = 1'b0;
            OP_LSB_ARI: sel.keep_sign  = 1'b1;
            default:    sel            = '0;
        endcase
    end

endmodule

// File: rtl/shcr_next.sv
module shcr_next
    import shcr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  sel_t             sel,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] load_data,
    output logic [WIDTH-1:0] nxt
);

    localparam int TOP = WIDTH - 1;

    logic top_fill;
    assign top_fill = sel.keep_sign & cur[TOP];

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic from_lower;
        logic from_upper;

        if (i == 0) begin : g_low_edge
            assign from_lower = 1'b0;
        end else begin : g_low_mid
            assign from_lower = cur[i-1];
        end

        if (i == TOP) begin : g_top_edge
            assign from_upper = top_fill;
        end else begin : g_top_mid
            assign from_upper = cur[i+1];
        end

        assign nxt[i] = sel.take_load  ? load_data[i] :
                        sel.take_lower ? from_lower   : from_upper;
    end

endmodule

// File: rtl/shift_cmd_reg.sv
module shift_cmd_reg
    import shcr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             arst,
    input  logic [WIDTH-1:0] load_data,
    input  logic [1:0]       op,
    output logic [WIDTH-1:0] value
);

    localparam int TOP = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] word;
    } state_t;

    state_t state_d, state_q;
    sel_t   sel;
    logic [WIDTH-1:0] nxt_word;

    shcr_decode u_decode (
        .op  (op),
        .sel (sel)
    );

    shcr_next #(.WIDTH(WIDTH)) u_next (
        .sel       (sel),
        .cur       (state_q.word),
        .load_data (load_data),
        .nxt       (nxt_word)
    );

    always_comb begin
        state_d      = state_q;
        state_d.word = nxt_word;
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign value = state_q.word;

    // R1: load captures the input word
    a_r1_load_word: assert property (@(posedge clk) disable iff (arst)
        (op == 2'b00) |=> (value == $past(load_data)));

    // R2: move toward MSB, zero into bit 0
    a_r2_to_msb: assert property (@(posedge clk) disable iff (arst)
        (op == 2'b01) |=> (value[0] == 1'b0) && (value[TOP:1] == $past(value[TOP-1:0])));

    // R3: logical move toward bit 0, zero into MSB
    a_r3_lsb_logical: assert property (@(posedge clk) disable iff (arst)
        (op == 2'b10) |=> (value[TOP] == 1'b0) && (value[TOP-1:0] == $past(value[TOP:1])));

    // R4: arithmetic move keeps the sign bit
    a_r4_lsb_sign: assert property (@(posedge clk) disable iff (arst)
        (op == 2'b11) |=> (value[TOP] == $past(value[TOP])) && (value[TOP-1:0] == $past(value[TOP:1])));

    // R7: all ones stays all ones under the arithmetic move
    a_r7_ones_fixed: assert property (@(posedge clk) disable iff (arst)
        ((op == 2'b11) && (value == {WIDTH{1'b1}})) |=> (value == {WIDTH{1'b1}}));

endmodule

// File: tb/shift_cmd_reg_bench.sv
module shift_cmd_reg_bench;

    logic       clk = 1'b0;
    logic       arst = 1'b1;
    logic [7:0] load_data = 8'h00;
    logic [1:0] op = 2'b00;
    logic [7:0] value;

    int vectors = 0;
    int fails   = 0;

    shift_cmd_reg #(.WIDTH(8)) u_shift_cmd_reg (
        .clk       (clk),
        .arst      (arst),
        .load_data (load_data),
        .op        (op),
        .value     (value)
    );

    always #2.5 clk = ~clk;

    task automatic check(input logic [7:0] exp, input string req);
        vectors++;
        if (value !== exp) begin
            fails++;
            $display("FAIL %s: value=%02h expected=%02h", req, value, exp);
        end
    endtask

    function automatic logic [7:0] model(input logic [1:0] c, input logic [7:0] v, input logic [7:0] d);
        int n;
        n = int'(v);
        case (c)
            2'b00:   return d;
            2'b01:   return 8'((n * 2) % 256);
            2'b10:   return 8'(n / 2);
            default: return 8'(n / 2 + ((n >= 128) ? 128 : 0));
        endcase
    endfunction

    // drive on falling edge, sample 1 ns after the rising edge
    task automatic step(input logic [1:0] c, input logic [7:0] d);
        @(negedge clk);
        op = c;
        load_data = d;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: value=%02h expected=finished", value);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        // R5: reset state
        #7;
        check(8'h00, "R5 reset");
        @(negedge clk);
        arst = 1'b0;

        // R8: fixed sequence
        step(2'b00, 8'hC0); check(8'hC0, "R1 load C0");
        step(2'b01, 8'h00); check(8'h80, "R8 left");
        step(2'b10, 8'h00); check(8'h40, "R8 right1");
        step(2'b10, 8'h00); check(8'h20, "R8 right2");

        // R1..R4: every start word with every operation
        for (int v = 0; v < 256; v++) begin
            for (int c = 0; c < 4; c++) begin
                step(2'b00, 8'(v));
                check(8'(v), "R1 load");
                step(2'(c), 8'(255 - v));
                check(model(2'(c), 8'(v), 8'(255 - v)),
                      (c == 0) ? "R1 reload" : (c == 1) ? "R2 to msb" :
                      (c == 2) ? "R3 logical" : "R4 arithmetic");
            end
        end

        // R7: repeated arithmetic moves
        step(2'b00, 8'h9E);
        for (int k = 0; k < 8; k++) step(2'b11, 8'h00);
        check(8'hFF, "R7 negative converges");
        step(2'b00, 8'h62);
        for (int k = 0; k < 8; k++) step(2'b11, 8'h00);
        check(8'h00, "R7 positive converges");

        // R6: input changes between edges do not move the word
        step(2'b00, 8'h5A);
        @(negedge clk);
        op = 2'b01; load_data = 8'hFF;
        #1; check(8'h5A, "R6 op change");
        op = 2'b00; load_data = 8'h33;
        #1; check(8'h5A, "R6 data change");
        @(posedge clk); #1;
        check(8'h33, "R6 captured at edge");

        // R5: asynchronous clear mid-cycle
        @(negedge clk);
        op = 2'b11;
        arst = 1'b1;
        #1; check(8'h00, "R5 async clear");
        @(posedge clk); #1;
        check(8'h00, "R5 held in reset");
        @(negedge clk);
        arst = 1'b0;
        step(2'b00, 8'h81); check(8'h81, "R1 after reset");
        step(2'b11, 8'h00); check(8'hC0, "R4 after reset");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule